// File: doc/BRIEF.md
# SPI Flash Command-Register Controller

The block gives a register-bus master a simple way to drive a serial NOR flash. Writing a word to the command register starts a flash transaction: the opcode sits in bits 31:24 and, for addressed opcodes, a 24-bit byte address in bits 23:0. Chip select is pulled low and the opcode and address go out on the wire. Chip select then stays low, so the transaction remains open across any number of later data-register accesses. It closes only when software writes a command whose opcode byte is zero, or when a short set of opcodes closes itself.

While a transaction is open, each read of the data register clocks four bytes in from the flash. Each write of the data register clocks four bytes out. This lets software stream a 256-byte page as 64 dword accesses, or poll the flash status byte with repeated reads. For page programming, the first dword is written to the data register before the command, while no transaction is open. The command then sends it after the address.

A control register holds a controller reset bit and a two-bit clock-rate field. Register accesses that need the shifter stall through a valid/ready handshake until the shifter is free.

Top module: `spi_cmd_ctrl`

## Requirements
- R1: After reset, chip select is high, SCK is low, and the control register reads 0x0000_0020 (rate 2, reset bit clear, open flag clear).
- R2: A command with opcode 0x02, 0x03, 0x20, 0x52 or 0xD8 sends the opcode byte and then address bits 23:16, 15:8 and 7:0, and leaves chip select low.
- R3: A command with any other non-zero opcode sends only the opcode byte. For 0x06, 0x60 and 0xAB, chip select then rises on its own; for the others (for example 0x05, 0x90) it stays low.
- R4: A command whose opcode byte is 0x00 raises chip select and sends nothing. Control-register bit 8 reads 1 while a transaction is open and 0 otherwise.
- R5: A non-zero command written while a transaction is open first holds chip select high for at least 2 clock cycles, then starts a new transaction.
- R6: A data-register read while a transaction is open clocks in 4 bytes with MOSI low and returns them with the first byte in bits 7:0. A data-register read with no open transaction returns 0 and produces no SCK edge.
- R7: A data-register write while a transaction is open sends 4 bytes: bits 7:0 first, then 15:8, 23:16 and 31:24.
- R8: A data-register write with no open transaction produces no SCK edge and stores the word. A later 0x02 command sends the opcode, 3 address bytes, and then the stored word in the byte order of R7.
- R9: SPI mode 0: SCK is low whenever chip select is high, each byte goes out MSB first, and MOSI does not change on a rising SCK edge.
- R10: Control bits 5:4 select the SCK period: 8 clocks for value 0, 4 clocks for value 1, and 2 clocks for value 2 or 3.
- R11: While control bit 0 is set, the controller aborts any transaction, keeps chip select high and SCK low, clears the stored word, ignores command and data writes, and returns 0 on data reads.
- R12: A command- or data-register access stalls with ready low while bytes are still shifting or a data read is being collected; control-register accesses are always ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Access completes on a cycle where valid and ready are both high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 2 | 0 control/status, 1 command, 2 data |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data, valid in the completing cycle |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that a requester holds valid, write, address and data steady until ready is seen. They also assume that the rate field is not rewritten while bytes are shifting, since one of them checks the full-speed SCK pulse width. The bench keeps to both rules: each access is issued by a single task that holds the request until completion. Rate changes are made only with no transaction open. A behavioural flash model records every MOSI byte per chip-select frame and serves a computed MISO stream. Against these, the bench checks bit order, the chip-select gap, the SCK period and the stall lengths on every clock.

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl #(
  parameter int GAP_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] req_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam int GW = $clog2(GAP_CYCLES + 1);

  logic          ctl_rst;
  logic [1:0]    rate;
  logic          open_q;
  logic [63:0]   tx_q;
  logic [3:0]    left_q;
  logic [2:0]    bit_q;
  logic [1:0]    div_q;
  logic [7:0]    rxb_q;
  logic [31:0]   rxw_q;
  logic [31:0]   latch_q;
  logic          close_q;
  logic          rdp_q;
  logic          rdd_q;
  logic [GW-1:0] gap_q;

  logic [7:0] op;
  logic       addressed;
  logic       autoclose;
  logic [1:0] half_m1;

  assign op = req_wdata[31:24];

  always_comb begin
    addressed = (op == 8'h02) || (op == 8'h03) || (op == 8'h20) ||
                (op == 8'h52) || (op == 8'hD8);
    autoclose = (op == 8'h06) || (op == 8'h60) || (op == 8'hAB);
  end

  always_comb begin
    case (rate)
      2'd0:    half_m1 = 2'd3;
      2'd1:    half_m1 = 2'd1;
      default: half_m1 = 2'd0;
    endcase
  end

  logic busy, is_ctl, rd_needs, fire, tick;
  logic [31:0] wswap, lswap;

  assign busy     = (left_q != '0) || (gap_q != '0);
  assign is_ctl   = (req_addr == A_CTL);
  assign rd_needs = req_valid && !req_write && (req_addr == A_DATA) && open_q && !ctl_rst;
  assign req_ready = is_ctl || (!busy && (!rd_needs || rdd_q));
  assign fire     = req_valid && req_ready;
  assign tick     = (div_q == half_m1);
  assign wswap    = {req_wdata[7:0], req_wdata[15:8], req_wdata[23:16], req_wdata[31:24]};
  assign lswap    = {latch_q[7:0], latch_q[15:8], latch_q[23:16], latch_q[31:24]};
  assign spi_mosi = tx_q[63] & ~spi_cs_n;

  always_comb begin
    case (req_addr)
      A_CTL:   req_rdata = {23'd0, open_q, 2'd0, rate, 3'd0, ctl_rst};
      A_DATA:  req_rdata = (open_q && !ctl_rst) ? rxw_q : 32'd0;
      default: req_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_rst  <= 1'b0;
      rate     <= 2'd2;
      open_q   <= 1'b0;
      tx_q     <= '0;
      left_q   <= '0;
      bit_q    <= '0;
      div_q    <= '0;
      rxb_q    <= '0;
      rxw_q    <= '0;
      latch_q  <= '0;
      close_q  <= 1'b0;
      rdp_q    <= 1'b0;
      rdd_q    <= 1'b0;
      gap_q    <= '0;
      spi_sck  <= 1'b0;
      spi_cs_n <= 1'b1;
    end else begin
      if (fire && req_write && is_ctl) begin
        ctl_rst <= req_wdata[0];
        rate    <= req_wdata[5:4];
      end
      if (ctl_rst) begin
        spi_cs_n <= 1'b1;
        spi_sck  <= 1'b0;
        open_q   <= 1'b0;
        tx_q     <= '0;
        left_q   <= '0;
        gap_q    <= '0;
        bit_q    <= '0;
        div_q    <= '0;
        rdp_q    <= 1'b0;
        rdd_q    <= 1'b0;
        close_q  <= 1'b0;
        latch_q  <= '0;
      end else if (gap_q != '0) begin
        gap_q <= gap_q - GW'(1);
        if (gap_q == GW'(1)) spi_cs_n <= 1'b0;
      end else if (left_q != '0) begin
        if (tick) begin
          div_q <= '0;
          if (!spi_sck) begin
            spi_sck <= 1'b1;
            rxb_q   <= {rxb_q[6:0], spi_miso};
          end else begin
            spi_sck <= 1'b0;
            tx_q    <= {tx_q[62:0], 1'b0};
            bit_q   <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              left_q <= left_q - 4'd1;
              rxw_q  <= {rxb_q, rxw_q[31:8]};
              if (left_q == 4'd1) begin
                if (close_q) begin
                  spi_cs_n <= 1'b1;
                  open_q   <= 1'b0;
                end
                if (rdp_q) begin
                  rdp_q <= 1'b0;
                  rdd_q <= 1'b1;
                end
              end
            end
          end
        end else begin
          div_q <= div_q + 2'd1;
        end
      end else if (fire && !is_ctl) begin
        if (req_addr == A_CMD && req_write) begin
          if (op == 8'h00) begin
            spi_cs_n <= 1'b1;
            open_q   <= 1'b0;
          end else begin
            open_q  <= 1'b1;
            close_q <= autoclose;
            bit_q   <= '0;
            div_q   <= '0;
            if (open_q) begin
              spi_cs_n <= 1'b1;
              gap_q    <= GW'(GAP_CYCLES);
            end else begin
              spi_cs_n <= 1'b0;
            end
            if (op == 8'h02) begin
              tx_q   <= {req_wdata, lswap};
              left_q <= 4'd8;
            end else if (addressed) begin
              tx_q   <= {req_wdata, 32'd0};
              left_q <= 4'd4;
            end else begin
              tx_q   <= {op, 56'd0};
              left_q <= 4'd1;
            end
          end
        end else if (req_addr == A_DATA && req_write) begin
          if (open_q) begin
            tx_q    <= {wswap, 32'd0};
            left_q  <= 4'd4;
            close_q <= 1'b0;
          end else begin
            latch_q <= req_wdata;
          end
        end else if (req_addr == A_DATA) begin
          rdd_q <= 1'b0;
        end
      end else if (rd_needs && !rdd_q) begin
        tx_q    <= '0;
        left_q  <= 4'd4;
        rdp_q   <= 1'b1;
        close_q <= 1'b0;
        bit_q   <= '0;
        div_q   <= '0;
      end
    end
  end

endmodule

// File: rtl/spi_cmd_ctrl_chk.sv
module spi_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [1:0]  req_addr,
  input logic [31:0] req_wdata,
  input logic        spi_sck,
  input logic        spi_cs_n,
  input logic        spi_mosi,
  input logic        ctl_rst,
  input logic [1:0]  rate
);

  a_r9_sck_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  a_r9_mosi_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi));

  a_r4_nop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == 2'd1 &&
     req_wdata[31:24] == 8'h00 && !ctl_rst) |=> spi_cs_n);

  a_r11_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |=> (spi_cs_n && !spi_sck));

  a_r10_full_speed: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(spi_sck) && rate == 2'd2 && !ctl_rst) |=> $fell(spi_sck));

  a_r12_stall_mid_byte: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !(req_valid && req_ready && req_addr != 2'd0));

endmodule

bind spi_cmd_ctrl spi_cmd_ctrl_chk chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
  .ctl_rst(ctl_rst), .rate(rate)
);

// File: tb/spi_cmd_ctrl_test.sv
module spi_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  spi_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rdata(req_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] mo[$];
  int s_cnt = 0, rises = 0, since_rise = 0, period = 0;
  int hi_run = 0, last_gap = 0;
  logic [7:0] sh = '0;
  logic sck_prev = 1'b0, mosi_prev = 1'b0;

  function automatic logic [7:0] resp(int n);
    return 8'((n * 29 + 90) % 256);
  endfunction

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_mo(string tag, int n, logic [63:0] v);
    bit ok;
    logic [63:0] got;
    ok = (mo.size() == n);
    got = '0;
    foreach (mo[i]) got = {got[55:0], mo[i]};
    for (int i = 0; i < n && ok; i++)
      if (mo[i] !== v[8*(n-1-i) +: 8]) ok = 0;
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d bytes %h expected=%0d bytes %h", tag, mo.size(), got, n, v);
    end
  endtask

  // Behavioural flash model and per-clock wire checks
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (spi_cs_n && spi_sck) begin
        errors++;
        $display("FAIL R9 actual=sck high with cs high expected=sck low");
      end
      since_rise++;
      if (spi_cs_n) begin
        s_cnt = 0;
        hi_run++;
      end else begin
        if (hi_run != 0) last_gap = hi_run;
        hi_run = 0;
        if (spi_sck && !sck_prev) begin
          checks++;
          if (spi_mosi !== mosi_prev) begin
            errors++;
            $display("FAIL R9 actual=mosi %b expected=%b at rising sck", spi_mosi, mosi_prev);
          end
          rises++;
          if (s_cnt > 0) period = since_rise;
          since_rise = 0;
          sh = {sh[6:0], spi_mosi};
          if (s_cnt % 8 == 7) mo.push_back(sh);
          s_cnt++;
        end
      end
      spi_miso = resp(s_cnt / 8)[7 - (s_cnt % 8)];
    end
    sck_prev = spi_sck;
    mosi_prev = spi_mosi;
  end

  task automatic bus(input bit wr, input logic [1:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int waits);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    waits = 0;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
      waits++;
    end
    rd = req_rdata;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    logic [31:0] r;
    int w;
    bus(1'b1, a, d, r, w);
  endtask

  task automatic wait_idle();
    req_addr = 2'd2;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R12 watchdog actual=hung expected=completion");
    summary();
  end

  initial begin
    logic [31:0] r;
    int w, r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    check_eq("R1 cs_n", {31'd0, spi_cs_n}, 1);
    check_eq("R1 sck", {31'd0, spi_sck}, 0);
    bus(1'b0, 2'd0, 0, r, w);
    check_eq("R1 ctl", r, 32'h20);

    // R3 auto close
    mo.delete(); wr(2'd1, 32'h0600_0000); wait_idle();
    check_mo("R3 wren bytes", 1, 64'h06);
    check_eq("R3 wren closes", {31'd0, spi_cs_n}, 1);

    // R2 addressed read command
    mo.delete(); wr(2'd1, 32'h0312_3456); wait_idle();
    check_mo("R2 read cmd bytes", 4, 64'h0312_3456);
    check_eq("R2 stays open", {31'd0, spi_cs_n}, 0);
    bus(1'b0, 2'd0, 0, r, w);
    check_eq("R4 open flag", r, 32'h120);

    // R6 data reads, R12 stall
    mo.delete(); bus(1'b0, 2'd2, 0, r, w);
    check_eq("R6 first read", r, {resp(7), resp(6), resp(5), resp(4)});
    check_mo("R6 mosi low", 4, 64'h0);
    checks++;
    if (w < 60) begin errors++; $display("FAIL R12 actual=%0d expected>=60 wait cycles", w); end
    bus(1'b0, 2'd2, 0, r, w);
    check_eq("R6 second read", r, {resp(11), resp(10), resp(9), resp(8)});

    // R5 new command while open, R3 status stays open
    mo.delete(); wr(2'd1, 32'h0500_0000); wait_idle();
    checks++;
    if (last_gap < 2) begin errors++; $display("FAIL R5 actual=%0d expected>=2 gap", last_gap); end
    check_mo("R5 status opcode", 1, 64'h05);
    check_eq("R3 status open", {31'd0, spi_cs_n}, 0);
    bus(1'b0, 2'd2, 0, r, w);
    check_eq("R6 status read", r, {resp(4), resp(3), resp(2), resp(1)});

    // R4 NOP
    wr(2'd1, 32'h0000_0000); @(negedge clk);
    check_eq("R4 nop closes", {31'd0, spi_cs_n}, 1);
    bus(1'b0, 2'd0, 0, r, w);
    check_eq("R4 open flag clear", r, 32'h20);

    // R6 closed read
    r0 = rises; bus(1'b0, 2'd2, 0, r, w);
    check_eq("R6 closed read data", r, 0);
    check_eq("R6 closed read no sck", rises, r0);

    // R8 page program
    mo.delete(); r0 = rises; wr(2'd2, 32'hA1B2_C3D4); @(negedge clk);
    check_eq("R8 preload no sck", rises, r0);
    wr(2'd1, 32'h0200_0100); wait_idle();
    check_mo("R8 program bytes", 8, 64'h0200_0100_D4C3_B2A1);

    // R7 data write, R12 control always ready
    mo.delete(); wr(2'd2, 32'h1122_3344);
    bus(1'b0, 2'd0, 0, r, w);
    check_eq("R12 ctl ready while busy", w, 0);
    wait_idle();
    check_mo("R7 write bytes", 4, 64'h4433_2211);
    wr(2'd1, 32'h0);

    // R10 rates
    for (int k = 0; k < 4; k++) begin
      logic [1:0] rv;
      int exp_p;
      rv = (k == 0) ? 2'd0 : (k == 1) ? 2'd1 : (k == 2) ? 2'd3 : 2'd2;
      exp_p = (rv == 2'd0) ? 8 : (rv == 2'd1) ? 4 : 2;
      wr(2'd0, {26'd0, rv, 4'd0});
      mo.delete(); wr(2'd1, 32'h6000_0000); wait_idle();
      check_eq("R10 sck period", period, exp_p);
      check_mo("R10 chip erase byte", 1, 64'h60);
    end

    // R11 controller reset
    wr(2'd1, 32'h0300_0000); wait_idle();
    wr(2'd0, 32'h21); repeat (3) @(negedge clk);
    check_eq("R11 cs high", {31'd0, spi_cs_n}, 1);
    bus(1'b0, 2'd0, 0, r, w);
    check_eq("R11 ctl value", r, 32'h21);
    r0 = rises;
    wr(2'd2, 32'h0000_0055); wr(2'd1, 32'h0600_0000); repeat (20) @(negedge clk);
    check_eq("R11 writes ignored", rises, r0);
    bus(1'b0, 2'd2, 0, r, w);
    check_eq("R11 read zero", r, 0);
    wr(2'd0, 32'h20);
    mo.delete(); wr(2'd1, 32'h0200_0000); wait_idle();
    check_mo("R11 stored word cleared", 8, 64'h0200_0000_0000_0000);
    wr(2'd1, 32'h0);

    // R11 abort mid-shift
    wr(2'd1, 32'h03AB_CDEF); repeat (10) @(negedge clk);
    wr(2'd0, 32'h21); repeat (2) @(negedge clk);
    check_eq("R11 abort cs", {31'd0, spi_cs_n}, 1);
    check_eq("R11 abort sck", {31'd0, spi_sck}, 0);
    wr(2'd0, 32'h20);
    bus(1'b0, 2'd0, 0, r, w);
    check_eq("R11 released", r, 32'h20);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule